// File: doc/BRIEF.md
# Vectored Multi-Bank Interrupt Controller

This block gathers up to 96 interrupt sources, arranged as three banks of 32. It latches each source into a pending bit. An enable bit and a separate mask bit together decide whether that pending bit may reach the processor. Among the sources that may reach it, the lowest-numbered one is chosen. Its number is published in a vector register, and a single interrupt request line is raised. Software reads the vector register, services that source and clears its pending bit. It repeats this until the vector register reads zero. Because zero also names source 0, software checks bit 0 of pending bank 0 to tell the two cases apart.

Source 0 is a special external line that is active low. A trigger register selects how it is latched: either as a low level or on a falling edge. A protection register is provided as plain storage. Fast-interrupt pending banks are present in the address space, but they read as zero.

Two small state machines drive the behaviour.

The line tracker records the last level of the source-0 line in states `LINE_HI` and `LINE_LO`:
- It moves `LINE_HI -> LINE_LO` when the line is sampled low.
- It moves `LINE_LO -> LINE_HI` when the line is sampled high.
- A falling edge is the condition "in `LINE_HI` with the line low".

The delivery machine has states `DLV_IDLE` and `DLV_ACTIVE`:
- It moves `DLV_IDLE -> DLV_ACTIVE` when any deliverable source exists.
- It moves `DLV_ACTIVE -> DLV_IDLE` when none remains.
- The request line is high exactly in `DLV_ACTIVE`.
- The registered vector is updated on the same edges.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, every enable, mask and pending bit is 0, the trigger and protection registers read 0, the vector reads 0 and `cpu_irq` is low.
- R2: For source k from 1 to 95, the pending bit k mod 32 in bank k/32 becomes 1 at the first clock edge where input k is high. Pending bank n is read at byte address 0x10+4n.
- R3: Writing to pending bank n clears every bit written as 1 and leaves every bit written as 0. If the source requests a set in the same cycle, the set wins, so a source whose input is still high reads pending again.
- R4: A pending source is deliverable only while its bit in enable bank n (address 0x40+4n) is 1.
- R5: A 1 in mask bank n (address 0x50+4n) blocks its source even when that source is enabled. A 0 lets it through.
- R6: A read of address 0x00 returns the lowest-numbered deliverable source in bits [8:2], with bits [1:0] zero. It returns 0 when nothing is deliverable.
- R7: `cpu_irq` is high exactly when a deliverable source exists. Both `cpu_irq` and the vector follow a change in pending, enable or mask one clock edge later.
- R8: When the trigger register (address 0x0C, bit 0) holds 0, pending bit 0 is set at every edge where `src_i[0]` is low.
- R9: When the trigger register holds 1, pending bit 0 is set only on a high-to-low transition of `src_i[0]`. It stays set until it is cleared by a write, and holding the line low does not set it again.
- R10: The protection register at address 0x08 reads back the last 32-bit value written to it.
- R11: Fast-interrupt pending addresses 0x20+4n always read 0, and writes to them change nothing. Read data is captured at the edge where `bus_re` is high and is held until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 96 | Interrupt sources; bit 0 active low, others active high |
| bus_addr | input | 8 | Byte address of register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
Two functions can fall in the same cycle: a write-one-to-clear of a pending bit and a new set request for that same source. The set may come from a high level or from a fresh falling edge on source 0. The bench provokes this by clearing a bank while its input is still high. A random phase also mixes source toggles and clearing writes on the same edges. Each case is judged against a behavioural model in which the set takes precedence. That model is compared against `cpu_irq` and the read data on every clock.

// File: rtl/vic_pkg.sv
`timescale 1ns/1ps
package vic_pkg;
    localparam int NBANK_DEF = 3;
    localparam int BANKW_DEF = 32;

    localparam logic [3:0] RG_CTRL = 4'h0;
    localparam logic [3:0] RG_PEND = 4'h1;
    localparam logic [3:0] RG_FAST = 4'h2;
    localparam logic [3:0] RG_EN   = 4'h4;
    localparam logic [3:0] RG_MASK = 4'h5;

    localparam logic [3:0] OFF_VEC  = 4'h0;
    localparam logic [3:0] OFF_PROT = 4'h8;
    localparam logic [3:0] OFF_TRIG = 4'hC;

    typedef enum logic {DLV_IDLE = 1'b0, DLV_ACTIVE = 1'b1} dlv_state_t;
    typedef enum logic {LINE_HI = 1'b0, LINE_LO = 1'b1} line_state_t;
    typedef enum logic {TRIG_LEVEL_LOW = 1'b0, TRIG_FALL_EDGE = 1'b1} trig_mode_t;
endpackage

// File: rtl/vic_bank.sv
`timescale 1ns/1ps
module vic_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         wr_pend_i,
    input  logic         wr_en_i,
    input  logic         wr_mask_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] pend_o,
    output logic [W-1:0] en_o,
    output logic [W-1:0] mask_o
);
    logic [W-1:0] clr_bits;

    assign clr_bits = wr_pend_i ? wdata_i : '0;

    // set requests override a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_o <= '0;
        end else begin
            pend_o <= (pend_o & ~clr_bits) | set_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_o <= '0;
        end else if (wr_en_i) begin
            en_o <= wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_o <= '0;
        end else if (wr_mask_i) begin
            mask_o <= wdata_i;
        end
    end
endmodule

// File: rtl/vic_src0.sv
`timescale 1ns/1ps
module vic_src0
    import vic_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_n_i,
    input  trig_mode_t mode_i,
    output logic       set_o
);
    line_state_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= LINE_HI;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LINE_HI: if (!line_n_i) st_d = LINE_LO;
            LINE_LO: if (line_n_i)  st_d = LINE_HI;
        endcase
    end

    always_comb begin
        unique case (mode_i)
            TRIG_LEVEL_LOW: set_o = !line_n_i;
            TRIG_FALL_EDGE: set_o = (st_q == LINE_HI) && !line_n_i;
        endcase
    end
endmodule

// File: rtl/vic_prio.sv
`timescale 1ns/1ps
module vic_prio #(
    parameter int N  = 96,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req_i,
    output logic          hit_o,
    output logic [IW-1:0] idx_o
);
    // scan downward so the lowest set index is the last one kept
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                hit_o = 1'b1;
                idx_o = IW'(i);
            end
        end
    end
endmodule

// File: rtl/vic_dlv.sv
`timescale 1ns/1ps
module vic_dlv
    import vic_pkg::*;
#(
    parameter int IW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit_i,
    input  logic [IW-1:0] idx_i,
    output logic          irq_o,
    output logic [IW-1:0] vec_o
);
    dlv_state_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= DLV_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            DLV_IDLE:   if (hit_i)  st_d = DLV_ACTIVE;
            DLV_ACTIVE: if (!hit_i) st_d = DLV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_o <= '0;
        end else begin
            vec_o <= hit_i ? idx_i : '0;
        end
    end

    assign irq_o = (st_q == DLV_ACTIVE);
endmodule

// File: rtl/irq_vector_ctrl.sv
`timescale 1ns/1ps
module irq_vector_ctrl
    import vic_pkg::*;
#(
    parameter int NBANK = NBANK_DEF,
    parameter int BANKW = BANKW_DEF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NBANK*BANKW-1:0] src_i,
    input  logic [7:0]             bus_addr,
    input  logic                   bus_we,
    input  logic [BANKW-1:0]       bus_wdata,
    input  logic                   bus_re,
    output logic [BANKW-1:0]       bus_rdata,
    output logic                   cpu_irq
);
    localparam int NSRC = NBANK * BANKW;
    localparam int IDXW = $clog2(NSRC);
    localparam int BSW  = 2;

    logic [3:0]       region;
    logic [BSW-1:0]   bsel;
    logic [3:0]       offs;
    logic             unused_lo;
    logic [NSRC-1:0]  set_all, pend_all, en_all, mask_all;
    logic             src0_set;
    logic             trig_q;
    logic [BANKW-1:0] prot_q;
    logic             hit;
    logic [IDXW-1:0]  hit_idx, vec_q;
    logic [BANKW-1:0] rd_d, rd_p, rd_e, rd_m;

    assign region    = bus_addr[7:4];
    assign bsel      = bus_addr[3:2];
    assign offs      = bus_addr[3:0];
    assign unused_lo = ^bus_addr[1:0];

    vic_src0 u_src0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_n_i (src_i[0]),
        .mode_i   (trig_mode_t'(trig_q)),
        .set_o    (src0_set)
    );

    assign set_all = {src_i[NSRC-1:1], src0_set};

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic wp, wen, wmk;
        assign wp  = bus_we && (region == RG_PEND) && (bsel == BSW'(b));
        assign wen = bus_we && (region == RG_EN)   && (bsel == BSW'(b));
        assign wmk = bus_we && (region == RG_MASK) && (bsel == BSW'(b));

        vic_bank #(.W(BANKW)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_i     (set_all[b*BANKW +: BANKW]),
            .wr_pend_i (wp),
            .wr_en_i   (wen),
            .wr_mask_i (wmk),
            .wdata_i   (bus_wdata),
            .pend_o    (pend_all[b*BANKW +: BANKW]),
            .en_o      (en_all[b*BANKW +: BANKW]),
            .mask_o    (mask_all[b*BANKW +: BANKW])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_q <= 1'b0;
            prot_q <= '0;
        end else if (bus_we && region == RG_CTRL) begin
            if (offs == OFF_TRIG) trig_q <= bus_wdata[0];
            if (offs == OFF_PROT) prot_q <= bus_wdata;
        end
    end

    vic_prio #(.N(NSRC), .IW(IDXW)) u_prio (
        .req_i (pend_all & en_all & ~mask_all),
        .hit_o (hit),
        .idx_o (hit_idx)
    );

    vic_dlv #(.IW(IDXW)) u_dlv (
        .clk   (clk),
        .rst_n (rst_n),
        .hit_i (hit),
        .idx_i (hit_idx),
        .irq_o (cpu_irq),
        .vec_o (vec_q)
    );

    always_comb begin
        rd_p = '0;
        rd_e = '0;
        rd_m = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (bsel == BSW'(b)) begin
                rd_p = pend_all[b*BANKW +: BANKW];
                rd_e = en_all[b*BANKW +: BANKW];
                rd_m = mask_all[b*BANKW +: BANKW];
            end
        end
        rd_d = '0;
        case (region)
            RG_CTRL: begin
                case (offs)
                    OFF_VEC:  rd_d = BANKW'({vec_q, 2'b00});
                    OFF_PROT: rd_d = prot_q;
                    OFF_TRIG: rd_d = BANKW'(trig_q);
                    default:  rd_d = '0;
                endcase
            end
            RG_PEND: rd_d = rd_p;
            RG_FAST: rd_d = '0;
            RG_EN:   rd_d = rd_e;
            RG_MASK: rd_d = rd_m;
            default: rd_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_re) begin
            bus_rdata <= rd_d;
        end
    end
endmodule

// File: rtl/vic_ctrl_chk.sv
`timescale 1ns/1ps
module vic_ctrl_chk #(
    parameter int NSRC = 96
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] src_i,
    input logic [7:0]      bus_addr,
    input logic            bus_we,
    input logic [1:0]      wdat_lo,
    input logic            bus_re,
    input logic [31:0]     bus_rdata,
    input logic            cpu_irq,
    input logic [NSRC-1:0] pend_all,
    input logic [NSRC-1:0] en_all,
    input logic [NSRC-1:0] mask_all,
    input logic            trig_q
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (en_all == '0 && mask_all == '0 && pend_all == '0 && !cpu_irq));

    assert_level_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i[NSRC-1:1] != '0) |=>
        ((pend_all[NSRC-1:1] & $past(src_i[NSRC-1:1])) == $past(src_i[NSRC-1:1])));

    assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 8'h10 && wdat_lo[1] && !src_i[1]) |=> !pend_all[1]);

    assert_irq_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend_all & en_all & ~mask_all)) |=> cpu_irq);

    assert_irq_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(pend_all & en_all & ~mask_all)) |=> !cpu_irq);

    assert_vec_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr == 8'h00) |=> (bus_rdata[1:0] == 2'b00 && bus_rdata[31:9] == '0));

    assert_level0_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_q && !src_i[0]) |=> pend_all[0]);

    assert_edge_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_q && pend_all[0] && !(bus_we && bus_addr == 8'h10 && wdat_lo[0])) |=> pend_all[0]);

    assert_fast_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr[7:4] == 4'h2) |=> (bus_rdata == '0));
endmodule

bind irq_vector_ctrl vic_ctrl_chk #(.NSRC(NSRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src_i),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .wdat_lo   (bus_wdata[1:0]),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .cpu_irq   (cpu_irq),
    .pend_all  (pend_all),
    .en_all    (en_all),
    .mask_all  (mask_all),
    .trig_q    (trig_q)
);

// File: tb/irq_vector_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] src = 96'd1;
    logic [7:0]  addr = 8'h00;
    logic        we = 1'b0;
    logic [31:0] wdata = 32'h0;
    logic        re = 1'b0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_vector_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src),
        .bus_addr  (addr),
        .bus_we    (we),
        .bus_wdata (wdata),
        .bus_re    (re),
        .bus_rdata (rdata),
        .cpu_irq   (irq)
    );

    // behavioural reference state
    logic [95:0] m_pend, m_en, m_mask;
    logic        m_trig, m_prev0, m_irq;
    int          m_vec;
    logic [31:0] m_prot, m_rd;

    function automatic logic [31:0] mread(input logic [7:0] a);
        int b;
        b = int'(a[3:2]);
        case (a[7:4])
            4'h0: begin
                case (a[3:0])
                    4'h0:    return 32'(m_vec) << 2;
                    4'h8:    return m_prot;
                    4'hC:    return {31'b0, m_trig};
                    default: return 32'h0;
                endcase
            end
            4'h1: return (b < 3) ? m_pend[b*32 +: 32] : 32'h0;
            4'h4: return (b < 3) ? m_en[b*32 +: 32] : 32'h0;
            4'h5: return (b < 3) ? m_mask[b*32 +: 32] : 32'h0;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin : model
        int lo, b;
        logic [95:0] setv, clrv;
        if (!rst_n) begin
            m_pend = '0; m_en = '0; m_mask = '0;
            m_trig = 1'b0; m_prev0 = 1'b1; m_irq = 1'b0;
            m_vec = 0; m_prot = '0; m_rd = '0;
        end else begin
            lo = -1;
            for (int k = 95; k >= 0; k--)
                if (m_pend[k] && m_en[k] && !m_mask[k]) lo = k;
            if (re) m_rd = mread(addr);
            m_irq = (lo >= 0);
            m_vec = (lo >= 0) ? lo : 0;
            setv = src;
            setv[0] = m_trig ? (m_prev0 && !src[0]) : !src[0];
            m_prev0 = src[0];
            clrv = '0;
            b = int'(addr[3:2]);
            if (we && addr[7:4] == 4'h1 && b < 3) clrv[b*32 +: 32] = wdata;
            m_pend = (m_pend & ~clrv) | setv;
            if (we) begin
                if (addr == 8'h08) m_prot = wdata;
                if (addr == 8'h0C) m_trig = wdata[0];
                if (addr[7:4] == 4'h4 && b < 3) m_en[b*32 +: 32] = wdata;
                if (addr[7:4] == 4'h5 && b < 3) m_mask[b*32 +: 32] = wdata;
            end
        end
    end

    // per-cycle comparison against the model (R6 R7 R11)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_chk++;
            if (irq !== m_irq) begin
                n_err++;
                $display("FAIL R7 cycle irq act=%b exp=%b", irq, m_irq);
            end
            n_chk++;
            if (rdata !== m_rd) begin
                n_err++;
                $display("FAIL R11 cycle rdata act=%h exp=%h", rdata, m_rd);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; re = 1'b1;
        @(negedge clk);
        re = 1'b0;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired act=running exp=finished");
            finish_run();
        end
    end

    initial begin : stim
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", {31'b0, irq}, 32'h0);
        rd(8'h00, v); chk("R1 vector", v, 32'h0);
        rd(8'h44, v); chk("R1 enable", v, 32'h0);
        rd(8'h54, v); chk("R1 mask", v, 32'h0);
        rd(8'h0C, v); chk("R1 trigger", v, 32'h0);
        rd(8'h08, v); chk("R1 protection", v, 32'h0);

        // R2 / R4: source 37 pends but is not enabled
        @(negedge clk); src[37] = 1'b1;
        idle(3);
        rd(8'h14, v); chk("R2 pend bank1", v, 32'h20);
        chk("R4 not enabled irq", {31'b0, irq}, 32'h0);

        // R7 latency and R6 vector
        wr(8'h44, 32'h20);
        chk("R7 one edge later irq", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk("R7 raised irq", {31'b0, irq}, 32'h1);
        rd(8'h00, v); chk("R6 vector 37", v, 32'd148);

        // R6 priority: 70 also deliverable, 37 still wins
        @(negedge clk); src[70] = 1'b1;
        wr(8'h48, 32'h40);
        idle(2);
        rd(8'h00, v); chk("R6 lowest wins", v, 32'd148);
        @(negedge clk); src[37] = 1'b0;
        wr(8'h14, 32'h20);
        idle(2);
        rd(8'h00, v); chk("R6 vector 70", v, 32'd280);

        // R3 clear with input still high; zero bits untouched
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h18, v); chk("R3 level resets", v, 32'h40);
        @(negedge clk); src[40] = 1'b1;
        @(negedge clk); src[40] = 1'b0;
        wr(8'h14, 32'hFFFF_FEFF);
        rd(8'h14, v); chk("R3 zero bit kept", v, 32'h100);
        wr(8'h14, 32'h100);
        rd(8'h14, v); chk("R3 cleared", v, 32'h0);

        // R5 mask blocks an enabled source
        wr(8'h58, 32'h40);
        idle(2);
        chk("R5 masked irq", {31'b0, irq}, 32'h0);
        rd(8'h00, v); chk("R5 masked vector", v, 32'h0);
        wr(8'h58, 32'h0);
        idle(2);
        chk("R5 unmasked irq", {31'b0, irq}, 32'h1);

        // R8 source 0 level-low mode
        wr(8'h40, 32'h1);
        @(negedge clk); src[0] = 1'b0;
        idle(3);
        rd(8'h00, v); chk("R8 vector zero", v, 32'h0);
        chk("R8 irq", {31'b0, irq}, 32'h1);
        rd(8'h10, v); chk("R8 pend bit0", v & 32'h1, 32'h1);
        @(negedge clk); src[0] = 1'b1;
        wr(8'h10, 32'h1);
        idle(2);
        rd(8'h10, v); chk("R8 cleared", v & 32'h1, 32'h0);
        rd(8'h00, v); chk("R6 back to 70", v, 32'd280);

        // R9 falling-edge mode
        wr(8'h0C, 32'h1);
        rd(8'h0C, v); chk("R9 trigger readback", v, 32'h1);
        @(negedge clk); src[0] = 1'b0;
        @(negedge clk); src[0] = 1'b1;
        idle(4);
        rd(8'h10, v); chk("R9 edge latched", v & 32'h1, 32'h1);
        rd(8'h00, v); chk("R9 vector zero", v, 32'h0);
        wr(8'h10, 32'h1);
        idle(1);
        rd(8'h10, v); chk("R9 edge cleared", v & 32'h1, 32'h0);
        @(negedge clk); src[0] = 1'b0;
        idle(3);
        wr(8'h10, 32'h1);
        idle(2);
        rd(8'h10, v); chk("R9 held low no reset", v & 32'h1, 32'h0);
        @(negedge clk); src[0] = 1'b1;

        // R10 protection storage
        wr(8'h08, 32'h1);
        rd(8'h08, v); chk("R10 protection", v, 32'h1);

        // R11 fast-interrupt space
        wr(8'h24, 32'hFFFF_FFFF);
        rd(8'h24, v); chk("R11 fast reads zero", v, 32'h0);
        idle(3);
        chk("R11 read data held", rdata, 32'h0);

        // random phase, judged every cycle by the model
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            src = {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom};
            src[0] = ($urandom_range(0, 3) != 0);
            we = ($urandom_range(0, 2) == 0);
            re = ($urandom_range(0, 1) == 0);
            wdata = ($urandom_range(0, 1) == 0) ? 32'hFFFF_FFFF : $urandom;
            case ($urandom_range(0, 12))
                0:  addr = 8'h00;  1: addr = 8'h08;  2: addr = 8'h0C;
                3:  addr = 8'h10;  4: addr = 8'h14;  5: addr = 8'h18;
                6:  addr = 8'h20;  7: addr = 8'h40;  8: addr = 8'h44;
                9:  addr = 8'h48; 10: addr = 8'h50; 11: addr = 8'h54;
                default: addr = 8'h58;
            endcase
        end
        @(negedge clk);
        we = 1'b0; re = 1'b0;
        idle(3);
        finish_run();
    end
endmodule